// File: doc/BRIEF.md
# Interleaved Waveform Memory Sequencer

This block holds arbitrary waveform vectors for a two-channel converter and plays them back at wide parallel rate. Each channel owns a pair of banks, one for even-indexed points and one for odd-indexed points. Every bank word is 64 bits and packs four 16-bit samples. Point 8n+2j sits in sample slot j of the even bank's word n. Point 8n+2j+1 sits in sample slot j of the odd bank's word n. Slot j occupies bits [16j+15:16j].

A host port reads or writes single bank words. A direction input picks write or read. A channel-select input picks channel A or B. A broadcast input sends a write to both channels at once. A playback engine walks both channels through the same window of words. The window begins at a start word and holds burst+1 words, so burst = points/8 − 1. In each output cycle, each channel presents eight samples in point order.

Top module: `wfm_seq_top`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `out_valid` and `port_rvalid` are low.
- R2: A host access with `cfg_write`=1 stores `port_wdata` at word `port_addr` of the even bank (`port_odd`=0) or the odd bank (`port_odd`=1). The channel is A when `cfg_sel_b`=0 and B when `cfg_sel_b`=1. The other channel's memory is left unchanged.
- R3: A host access with `cfg_write`=0 returns the addressed word on `port_rdata` in the next cycle, with a one-cycle `port_rvalid` pulse. `port_wdata` is ignored and memory is not modified.
- R4: When `cfg_both`=1, a write lands in both channels. A read with `cfg_both`=1 still takes its channel from `cfg_sel_b`.
- R5: While `play_en` is high, playback presents word `cfg_start` first and advances one word per cycle. After word `cfg_start`+`cfg_burst` it returns to `cfg_start`. `out_valid` is high in the cycle after each playing cycle.
- R6: Lane k of `out_a`/`out_b` occupies bits [16k+15:16k]. Lane 2j carries even-word slot j and lane 2j+1 carries odd-word slot j, so the eight lanes are in ascending point order.
- R7: Playback addresses are taken modulo 2048: after word 2047 the next word is 0 when the window extends past it.
- R8: Playback is unaffected by `cfg_write`, `cfg_sel_b` and `cfg_both`. Both channels use the same word address in every cycle.
- R9: A host write to the word that playback reads in the same cycle does not change the data shown for that pass. The new value appears on the next pass through that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start | input | 11 | Playback start word |
| cfg_burst | input | 11 | Playback window length in words, minus one |
| cfg_write | input | 1 | Host access direction, 1 = write, 0 = read |
| cfg_sel_b | input | 1 | Host channel select, 0 = A, 1 = B |
| cfg_both | input | 1 | Broadcast host writes to both channels |
| play_en | input | 1 | Run playback |
| port_req | input | 1 | Host access strobe |
| port_odd | input | 1 | Host bank select, 0 = even, 1 = odd |
| port_addr | input | 11 | Host word address |
| port_wdata | input | 64 | Host write word |
| port_rdata | output | 64 | Host read word |
| port_rvalid | output | 1 | Host read data valid |
| out_valid | output | 1 | Playback lanes valid |
| out_a | output | 128 | Channel A, eight 16-bit samples |
| out_b | output | 128 | Channel B, eight 16-bit samples |

## Verification
Playback runs over three patterns.

- A four-word window at word 0, with the control inputs toggling, checks the start word, the wrap at the burst end and that the control inputs have no effect on playback.
- A window straddling word 2047 separates the modulo wrap from the burst wrap.
- A two-word window with a host write landing on the word being read checks the read-before-write order.

Each channel and bank is written with distinct per-location patterns, so a lane swap, a bank swap or a channel swap shows as a mismatch. Read-back after single-channel, broadcast and ignored-data accesses checks that writes land only in the selected memories.

// File: rtl/wfm_pkg.sv
package wfm_pkg;
  localparam int unsigned NUM_CH = 2;

  typedef enum logic {
    BANK_EVEN = 1'b0,
    BANK_ODD  = 1'b1
  } bank_e;
endpackage

// File: rtl/wfm_bank.sv
module wfm_bank #(
  parameter int WORD_W = 64,
  parameter int DEPTH  = 2048,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     host_addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] host_q,
  input  logic [AW-1:0]     play_addr,
  output logic [WORD_W-1:0] play_q
);
  logic [WORD_W-1:0] mem [DEPTH];

  // host port: read-first write
  always_ff @(posedge clk) begin
    if (we) mem[host_addr] <= wdata;
    host_q <= mem[host_addr];
  end

  // playback port: read only, sees old data on collision
  always_ff @(posedge clk) begin
    play_q <= mem[play_addr];
  end
endmodule

// File: rtl/wfm_addr_seq.sv
module wfm_addr_seq #(
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          play_en,
  input  logic [AW-1:0] start,
  input  logic [AW-1:0] burst,
  output logic [AW-1:0] ptr,
  output logic          valid
);
  logic [AW-1:0] last_w;
  assign last_w = start + burst;  // modulo DEPTH by width

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr   <= '0;
      valid <= 1'b0;
    end else begin
      valid <= play_en;
      if (!play_en)           ptr <= start;
      else if (ptr == last_w) ptr <= start;
      else                    ptr <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/wfm_lane_pack.sv
module wfm_lane_pack #(
  parameter int SAMPLE_W = 16,
  parameter int SLOTS    = 4,
  localparam int WORD_W  = SAMPLE_W * SLOTS,
  localparam int LANES   = 2 * SLOTS
) (
  input  logic [WORD_W-1:0]         even_w,
  input  logic [WORD_W-1:0]         odd_w,
  output logic [LANES*SAMPLE_W-1:0] lanes
);
  for (genvar j = 0; j < SLOTS; j++) begin : g_slot
    assign lanes[(2*j)*SAMPLE_W   +: SAMPLE_W] = even_w[j*SAMPLE_W +: SAMPLE_W];
    assign lanes[(2*j+1)*SAMPLE_W +: SAMPLE_W] = odd_w[j*SAMPLE_W +: SAMPLE_W];
  end
endmodule

// File: rtl/wfm_seq_top.sv
module wfm_seq_top
  import wfm_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int SLOTS    = 4,
  parameter int DEPTH    = 2048,
  localparam int AW      = $clog2(DEPTH),
  localparam int WORD_W  = SAMPLE_W * SLOTS,
  localparam int OUT_W   = 2 * SLOTS * SAMPLE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     cfg_start,
  input  logic [AW-1:0]     cfg_burst,
  input  logic              cfg_write,
  input  logic              cfg_sel_b,
  input  logic              cfg_both,
  input  logic              play_en,
  input  logic              port_req,
  input  logic              port_odd,
  input  logic [AW-1:0]     port_addr,
  input  logic [WORD_W-1:0] port_wdata,
  output logic [WORD_W-1:0] port_rdata,
  output logic              port_rvalid,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_a,
  output logic [OUT_W-1:0]  out_b
);
  logic [AW-1:0]     play_ptr;
  logic [WORD_W-1:0] host_q [NUM_CH][2];
  logic [WORD_W-1:0] play_q [NUM_CH][2];
  logic [OUT_W-1:0]  lanes  [NUM_CH];
  logic              rd_valid;
  logic              rd_ch;
  bank_e             rd_bank;

  wfm_addr_seq #(.DEPTH(DEPTH)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .play_en (play_en),
    .start   (cfg_start),
    .burst   (cfg_burst),
    .ptr     (play_ptr),
    .valid   (out_valid)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic ch_hit;
    assign ch_hit = cfg_both | (cfg_sel_b == 1'(c));

    for (genvar b = 0; b < 2; b++) begin : g_bank
      logic we;
      assign we = port_req & cfg_write & ch_hit & (port_odd == 1'(b));

      wfm_bank #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_bank (
        .clk       (clk),
        .we        (we),
        .host_addr (port_addr),
        .wdata     (port_wdata),
        .host_q    (host_q[c][b]),
        .play_addr (play_ptr),
        .play_q    (play_q[c][b])
      );
    end

    wfm_lane_pack #(.SAMPLE_W(SAMPLE_W), .SLOTS(SLOTS)) u_pack (
      .even_w (play_q[c][BANK_EVEN]),
      .odd_w  (play_q[c][BANK_ODD]),
      .lanes  (lanes[c])
    );
  end

  assign out_a = lanes[0];
  assign out_b = lanes[1];

  // host read tracking: channel follows the select bit even in broadcast mode
  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= port_req & ~cfg_write;
    rd_ch   <= cfg_sel_b;
    rd_bank <= bank_e'(port_odd);
  end

  assign port_rvalid = rd_valid;
  assign port_rdata  = host_q[rd_ch][rd_bank];
endmodule

// File: rtl/wfm_seq_chk.sv
module wfm_seq_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          play_en,
  input logic [AW-1:0] cfg_start,
  input logic [AW-1:0] cfg_burst,
  input logic          port_req,
  input logic          cfg_write,
  input logic          port_rvalid,
  input logic          out_valid,
  input logic [AW-1:0] play_ptr
);
  logic [AW-1:0] win_end;
  assign win_end = cfg_start + cfg_burst;

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!out_valid && !port_rvalid)); // R1

  AST_READ_STROBE: assert property (@(posedge clk) disable iff (rst)
    (port_req && !cfg_write) |=> port_rvalid); // R3

  AST_NO_STRAY_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(port_req && !cfg_write) |=> !port_rvalid); // R3

  AST_PLAY_VALID: assert property (@(posedge clk) disable iff (rst)
    play_en |=> out_valid); // R5

  AST_IDLE_LOADS_START: assert property (@(posedge clk) disable iff (rst)
    !play_en |=> (play_ptr == $past(cfg_start))); // R5

  AST_WRAP_TO_START: assert property (@(posedge clk) disable iff (rst)
    (play_en && play_ptr == win_end) |=> (play_ptr == $past(cfg_start))); // R5

  AST_STEP_MODULO: assert property (@(posedge clk) disable iff (rst)
    (play_en && play_ptr != win_end) |=> (play_ptr == AW'($past(play_ptr) + 1'b1))); // R7
endmodule

bind wfm_seq_top wfm_seq_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .play_en     (play_en),
  .cfg_start   (cfg_start),
  .cfg_burst   (cfg_burst),
  .port_req    (port_req),
  .cfg_write   (cfg_write),
  .port_rvalid (port_rvalid),
  .out_valid   (out_valid),
  .play_ptr    (play_ptr)
);

// File: tb/sim_wfm_seq_top.sv
module sim_wfm_seq_top;
  localparam int DEPTH = 2048;
  localparam int AW    = 11;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] cfg_start, cfg_burst, port_addr;
  logic          cfg_write, cfg_sel_b, cfg_both, play_en, port_req, port_odd;
  logic [63:0]   port_wdata, port_rdata;
  logic          port_rvalid, out_valid;
  logic [127:0]  out_a, out_b;

  int n_cmp = 0;
  int n_bad = 0;

  wfm_seq_top u0 (.*);

  always #5 clk = ~clk;

  // reference model
  logic [63:0]   mm [2][2][DEPTH];
  logic [AW-1:0] mptr;
  string         ptag = "R5";

  logic [63:0]  rq_data[$];
  string        rq_tag[$];
  logic [127:0] pq_a[$], pq_b[$];
  string        pq_tag[$];

  function automatic logic [63:0] pat(int ch, int odd, int addr, int salt);
    return {8'(salt), 4'(ch), 4'(odd), 16'(addr), 32'(addr * 977 + salt * 131 + ch * 7 + odd * 3)};
  endfunction

  function automatic logic [127:0] pack(logic [63:0] ev, logic [63:0] od);
    logic [127:0] r;
    for (int k = 0; k < 8; k++)
      r[16*k +: 16] = (k % 2 == 1) ? od[16*(k/2) +: 16] : ev[16*(k/2) +: 16];
    return r;
  endfunction

  task automatic fail(string req, logic [127:0] got, logic [127:0] exp);
    n_bad++;
    $display("FAIL %s: got %h expected %h", req, got, exp);
  endtask

  // driver: predict expectations for the coming edge, then advance
  task automatic step();
    logic [AW-1:0] wend;
    wend = cfg_start + cfg_burst;
    if (play_en) begin
      pq_a.push_back(pack(mm[0][0][mptr], mm[0][1][mptr]));
      pq_b.push_back(pack(mm[1][0][mptr], mm[1][1][mptr]));
      pq_tag.push_back(ptag);
      mptr = (mptr == wend) ? cfg_start : AW'(mptr + 1);
    end else begin
      mptr = cfg_start;
    end
    if (port_req) begin
      if (cfg_write) begin
        for (int c = 0; c < 2; c++)
          if (cfg_both || (cfg_sel_b == 1'(c))) mm[c][port_odd][port_addr] = port_wdata;
      end else begin
        rq_data.push_back(mm[cfg_sel_b][port_odd][port_addr]);
        rq_tag.push_back(ptag);
      end
    end
    @(negedge clk);
    port_req = 1'b0;
  endtask

  task automatic wr(bit sel, bit both, bit odd, int addr, logic [63:0] d);
    cfg_write = 1'b1; cfg_sel_b = sel; cfg_both = both;
    port_odd = odd; port_addr = AW'(addr); port_wdata = d; port_req = 1'b1;
    step();
  endtask

  task automatic rd(bit sel, bit both, bit odd, int addr, string tag);
    ptag = tag;
    cfg_write = 1'b0; cfg_sel_b = sel; cfg_both = both;
    port_odd = odd; port_addr = AW'(addr); port_wdata = '1; port_req = 1'b1;
    step();
  endtask

  // monitor: compare outputs after each edge
  always @(posedge clk) begin
    #2;
    if (!rst && port_rvalid) begin
      if (rq_data.size() == 0) fail("R3 unexpected rvalid", {64'b0, port_rdata}, '0);
      else begin
        logic [63:0] e; string t;
        e = rq_data.pop_front(); t = rq_tag.pop_front();
        n_cmp++;
        if (port_rdata !== e) fail(t, {64'b0, port_rdata}, {64'b0, e});
      end
    end
    if (!rst && out_valid) begin
      if (pq_a.size() == 0) fail("R5 unexpected out_valid", out_a, '0);
      else begin
        logic [127:0] ea, eb; string t;
        ea = pq_a.pop_front(); eb = pq_b.pop_front(); t = pq_tag.pop_front();
        n_cmp++;
        if (out_a !== ea) fail({t, " chA"}, out_a, ea);
        if (out_b !== eb) fail({t, " chB"}, out_b, eb);
      end
    end
  end

  task automatic play(int n, string tag);
    ptag = tag;
    play_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      if (i % 2 == 1) begin cfg_write = ~cfg_write; cfg_sel_b = ~cfg_sel_b; cfg_both = ~cfg_both; end // R8
      step();
    end
    play_en = 1'b0;
    step();
    step();
  endtask

  task automatic finish_run();
    n_cmp++;
    if (pq_a.size() != 0 || rq_data.size() != 0)
      fail("R3 R5 leftover expectations", 128'(pq_a.size()), 128'(rq_data.size()));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; cfg_start = '0; cfg_burst = '0; cfg_write = 1'b0;
    cfg_sel_b = 1'b0; cfg_both = 1'b0; play_en = 1'b0; port_req = 1'b0;
    port_odd = 1'b0; port_addr = '0; port_wdata = '0; mptr = '0;
    repeat (3) @(negedge clk);
    n_cmp++;
    if (out_valid !== 1'b0) fail("R1 out_valid in reset", 128'(out_valid), 0);
    n_cmp++;
    if (port_rvalid !== 1'b0) fail("R1 port_rvalid in reset", 128'(port_rvalid), 0);
    rst = 1'b0;
    step(); step();

    // R2: B first, then A; read B back to see it untouched by A writes
    for (int w = 0; w < 4; w++)
      for (int b = 0; b < 2; b++) wr(1'b1, 1'b0, 1'(b), w, pat(1, b, w, 1));
    for (int w = 0; w < 4; w++)
      for (int b = 0; b < 2; b++) wr(1'b0, 1'b0, 1'(b), w, pat(0, b, w, 2));
    for (int w = 0; w < 4; w++) begin
      rd(1'b1, 1'b0, 1'b0, w, "R2 chB kept");
      rd(1'b0, 1'b0, 1'b1, w, "R2 chA odd");
    end

    // R3: read ignores port_wdata (all ones) and leaves memory unchanged
    rd(1'b0, 1'b0, 1'b0, 2, "R3 read");
    rd(1'b0, 1'b0, 1'b0, 2, "R3 reread unchanged");
    step();

    // R4: broadcast writes near the top and bottom of the address range
    for (int w = 2046; w < 2050; w++)
      for (int b = 0; b < 2; b++) wr(1'b0, 1'b1, 1'(b), w % DEPTH, pat(2, b, w % DEPTH, 3));
    rd(1'b1, 1'b1, 1'b0, 2047, "R4 both read chB");
    rd(1'b0, 1'b1, 1'b1, 1, "R4 both read chA");
    rd(1'b1, 1'b0, 1'b1, 2046, "R4 broadcast landed chB");
    step();

    // R5 R6 R8: 32-point window at word 0 (burst 3), controls toggling
    cfg_start = 11'd0; cfg_burst = 11'd3; step();
    play(10, "R5 R6 R8 window0");

    // R7: window straddling the top of memory
    cfg_start = 11'd2046; cfg_burst = 11'd3; cfg_write = 1'b0; cfg_both = 1'b0; step();
    play(9, "R7 modulo wrap");

    // R9: host write to the word being read this cycle
    cfg_start = 11'd0; cfg_burst = 11'd1; cfg_write = 1'b0; cfg_both = 1'b0; step();
    ptag = "R9 collision";
    play_en = 1'b1;
    begin
      bit done = 1'b0;
      for (int i = 0; i < 8; i++) begin
        if (!done && i > 1 && mptr == 11'd1) begin
          cfg_write = 1'b1; cfg_sel_b = 1'b0; cfg_both = 1'b0;
          port_odd = 1'b0; port_addr = 11'd1; port_wdata = pat(0, 0, 1, 9); port_req = 1'b1;
          done = 1'b1;
        end
        step();
      end
    end
    play_en = 1'b0;
    step(); step(); step();
    finish_run();
  end
endmodule